// File: doc/BRIEF.md
# Sized Add/AND Unit with Status Flags

This block is one arithmetic slice of a processor datapath. Each accepted request carries an operation, an operand size, two operands and the incoming carry flag. One clock later the block returns the result together with six status flags. It also returns a per-flag write-enable vector, which tells the flag register which flags this operation defines.

The supported operations are plain add, add with carry and bitwise AND. Each can work on a byte, a word or a doubleword. Operand bits above the selected size are discarded before any computation. Carry, sign and overflow are always taken at the top bit of the selected size.

Auxiliary carry and overflow are not produced by a second adder. Both are read back from the two operands and the result using XOR identities.

Top module: `sized_alu`

## Requirements
- R1: `out_valid` is high exactly one cycle after `in_valid` was high. When `in_valid` is low, `result`, `flags` and `flag_we` keep their previous values.
- R2: `size` selects the operand width: 2'b00 is 8 bits, 2'b01 is 16 bits, and 2'b10 or 2'b11 is 32 bits. Operand bits above the width are ignored, and result bits above the width read 0.
- R3: `op` 2'b00 adds the two operands, and 2'b01 adds the two operands plus `carry_in`. Either sum is truncated to the selected width. `carry_in` has no effect for any other `op`.
- R4: For both add operations, `flags[0]` (carry) is the carry out of the most significant bit of the selected width.
- R5: For both add operations, `flags[5]` (overflow) is the top bit of the selected width of (result XOR src) AND NOT (dst XOR src).
- R6: For both add operations, `flags[2]` (auxiliary carry) is the carry into bit 4, which equals bit 4 of dst XOR src XOR result.
- R7: `flags[4]` (sign) is the result's top bit at the selected width. `flags[3]` (zero) is set when the result is 0. `flags[1]` (parity) is set when the low 8 bits of the result hold an even number of ones. These rules hold at every width.
- R8: `op` 2'b10 produces dst AND src. It clears carry and overflow, and it leaves auxiliary carry unwritten: `flag_we[2]` is 0 and `flags[2]` reads 0.
- R9: `flag_we` is 6'b111111 for both add operations and 6'b111011 for AND. `op` 2'b11 is reserved: it writes no flag (`flag_we` is 0), and `result` and `flags` read 0.
- R10: While `rst_n` is low, `out_valid`, `result`, `flags` and `flag_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op | input | 2 | 00 add, 01 add with carry, 10 AND, 11 reserved |
| size | input | 2 | 00 byte, 01 word, 10/11 doubleword |
| dst | input | 32 | First operand |
| src | input | 32 | Second operand |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result strobe |
| result | output | 32 | Result, zero above the selected width |
| flags | output | 6 | {overflow, sign, zero, aux carry, parity, carry} |
| flag_we | output | 6 | Per-flag write enable, same bit order as flags |

## Verification
The adds are driven with operand pairs chosen to separate the flags from each other:
- 0x7F+0x01 sets overflow and auxiliary carry without setting carry.
- 0xFF+0x01 sets carry and zero without setting overflow.
- Two doubleword sign bits overflow into both carry and overflow.

Each pattern is repeated at a narrower width with nonzero upper operand bits. This shows that carry and sign are taken at the selected width and not at bit 31. Add with carry is run with `carry_in` both clear and set on the same operands. AND and the reserved opcode are run with `carry_in` set, which shows that the incoming carry leaks nowhere and that the write-enable vector drops the flags that are not defined.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DATA_W  = 32;
  localparam int FLAG_W  = 6;
  localparam int AUX_BIT = 4;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_ADC  = 2'b01,
    OP_AND  = 2'b10,
    OP_RSVD = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zer;
    logic aux;
    logic par;
    logic cry;
  } alu_flags_t;

  localparam logic [FLAG_W-1:0] WE_ARITH = 6'b111111;
  localparam logic [FLAG_W-1:0] WE_LOGIC = 6'b111011;

  // Mask covering the selected operand width.
  function automatic logic [DATA_W-1:0] width_mask(input logic [1:0] sz);
    case (sz)
      2'b00:   width_mask = DATA_W'(32'h0000_00FF);
      2'b01:   width_mask = DATA_W'(32'h0000_FFFF);
      default: width_mask = {DATA_W{1'b1}};
    endcase
  endfunction

  // Most significant bit of v at the selected width.
  function automatic logic msb_at(input logic [DATA_W-1:0] v, input logic [1:0] sz);
    case (sz)
      2'b00:   msb_at = v[7];
      2'b01:   msb_at = v[15];
      default: msb_at = v[DATA_W-1];
    endcase
  endfunction

  // 1 when the low byte holds an even number of ones.
  function automatic logic even_ones8(input logic [7:0] b);
    even_ones8 = ~(^b);
  endfunction
endpackage

// File: rtl/alu_size_dec.sv
module alu_size_dec
  import alu_pkg::*;
(
  input  logic [1:0]        size,
  output logic [DATA_W-1:0] mask,
  output logic [5:0]        carry_pos
);
  always_comb begin
    mask = width_mask(size);
    case (size)
      2'b00:   carry_pos = 6'd8;
      2'b01:   carry_pos = 6'd16;
      default: carry_pos = 6'(DATA_W);
    endcase
  end
endmodule

// File: rtl/alu_adder.sv
module alu_adder
  import alu_pkg::*;
(
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic [DATA_W-1:0] mask,
  input  logic [5:0]        carry_pos,
  output logic [DATA_W-1:0] sum,
  output logic              carry_out
);
  logic [DATA_W:0] wide;

  always_comb begin
    wide      = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
    sum       = wide[DATA_W-1:0] & mask;
    carry_out = wide[carry_pos];
  end
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
  import alu_pkg::*;
(
  input  alu_op_e           op,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] r,
  input  logic              carry_out,
  output alu_flags_t        flags,
  output logic [FLAG_W-1:0] we
);
  logic [DATA_W-1:0] ovf_vec;
  logic [DATA_W-1:0] half_vec;
  logic              is_arith;

  always_comb begin
    is_arith = (op == OP_ADD) || (op == OP_ADC);
    ovf_vec  = (r ^ b) & ~(a ^ b);
    half_vec = a ^ b ^ r;
    flags    = '0;
    we       = '0;
    if (op != OP_RSVD) begin
      flags.sgn = msb_at(r, size);
      flags.zer = (r == '0);
      flags.par = even_ones8(r[7:0]);
    end
    if (is_arith) begin
      flags.cry = carry_out;
      flags.ovf = msb_at(ovf_vec, size);
      flags.aux = half_vec[AUX_BIT];
      we        = WE_ARITH;
    end else if (op == OP_AND) begin
      we        = WE_LOGIC;
    end
  end

  // R8: logic op never reports carry/overflow or writes aux
  always_comb begin
    if (op == OP_AND) begin
      a_r8_and_clears : assert (!flags.cry && !flags.ovf && !we[2]);
    end
  end
endmodule

// File: rtl/sized_alu.sv
module sized_alu
  import alu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [1:0]  op,
  input  logic [1:0]  size,
  input  logic [31:0] dst,
  input  logic [31:0] src,
  input  logic        carry_in,
  output logic        out_valid,
  output logic [31:0] result,
  output logic [5:0]  flags,
  output logic [5:0]  flag_we
);
  alu_op_e           op_e;
  logic [DATA_W-1:0] mask;
  logic [5:0]        carry_pos;
  logic [DATA_W-1:0] a_m, b_m, sum, res_next;
  logic              cin_eff, carry_out;
  alu_flags_t        flags_next;
  logic [FLAG_W-1:0] we_next;
  logic [DATA_W-1:0] mask_q;
  alu_op_e           op_q;

  assign op_e    = alu_op_e'(op);
  assign a_m     = dst & mask;
  assign b_m     = src & mask;
  assign cin_eff = (op_e == OP_ADC) & carry_in;

  alu_size_dec u_dec (
    .size(size), .mask(mask), .carry_pos(carry_pos)
  );

  alu_adder u_add (
    .a(a_m), .b(b_m), .cin(cin_eff), .mask(mask), .carry_pos(carry_pos),
    .sum(sum), .carry_out(carry_out)
  );

  always_comb begin
    case (op_e)
      OP_AND:  res_next = a_m & b_m;
      OP_RSVD: res_next = '0;
      default: res_next = sum;
    endcase
  end

  alu_flag_gen u_flags (
    .op(op_e), .size(size), .a(a_m), .b(b_m), .r(res_next),
    .carry_out(carry_out), .flags(flags_next), .we(we_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags     <= '0;
      flag_we   <= '0;
      mask_q    <= '0;
      op_q      <= OP_ADD;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= res_next;
        flags   <= flags_next;
        flag_we <= we_next;
        mask_q  <= mask;
        op_q    <= op_e;
      end
    end
  end

  // R1: one-cycle latency
  a_r1_valid_follows : assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_no_spurious : assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r1_hold : assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_valid) |=> $stable(result) && $stable(flags));
  // R2: nothing above the selected width
  a_r2_upper_clear : assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((result & ~mask_q) == '0));
  // R9: reserved op writes no flag
  a_r9_rsvd_silent : assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_q == OP_RSVD) |-> (flag_we == '0 && result == '0));
  // R8: logic op enables
  a_r8_and_we : assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_q == OP_AND) |-> (flag_we == WE_LOGIC));
endmodule

// File: tb/sized_alu_tb_top.sv
module sized_alu_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [31:0] res;
    logic [5:0]  flg;
    logic [5:0]  we;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [1:0]  size = 2'b00;
  logic [31:0] dst = '0;
  logic [31:0] src = '0;
  logic        carry_in = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic [5:0]  flags;
  logic [5:0]  flag_we;

  int   total = 0;
  int   bad = 0;
  bit   done = 0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sized_alu dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .size(size),
    .dst(dst), .src(src), .carry_in(carry_in), .out_valid(out_valid),
    .result(result), .flags(flags), .flag_we(flag_we)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Independent reference model: widths as integers, flags by arithmetic.
  function automatic exp_t model(input logic [1:0] o, input logic [1:0] s,
                                 input logic [31:0] d, input logic [31:0] b,
                                 input logic c, input string tag);
    exp_t   e;
    int     w;
    longint m, x, y, sum, r;
    int     ones;
    logic   cy, ov, ax, sg;
    w = (s == 2'b00) ? 8 : (s == 2'b01) ? 16 : 32;
    m = (64'd1 << w) - 1;
    x = d & m;
    y = b & m;
    cy = 0; ov = 0; ax = 0;
    if (o == 2'b00 || o == 2'b01) begin
      sum = x + y + ((o == 2'b01) ? longint'(c) : 0);
      r   = sum & m;
      cy  = sum[w];
      ax  = (((x & 15) + (y & 15) + ((o == 2'b01) ? longint'(c) : 0)) >> 4) != 0;
      ov  = (x[w-1] == y[w-1]) && (r[w-1] != x[w-1]);
      e.we = 6'b111111;
    end else if (o == 2'b10) begin
      r = x & y;
      e.we = 6'b111011;
    end else begin
      r = 0;
      e.we = 6'b000000;
    end
    ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(r[i]);
    sg = r[w-1];
    e.res = r[31:0];
    if (o == 2'b11) e.flg = 6'b0;
    else e.flg = {ov, sg, (r == 0), ax, (ones % 2 == 0), cy};
    e.tag = tag;
    return e;
  endfunction

  task automatic drive(input logic [1:0] o, input logic [1:0] s,
                       input logic [31:0] d, input logic [31:0] b,
                       input logic c, input string tag);
    sb.push_back(model(o, s, d, b, c, tag));
    @(negedge clk);
    in_valid = 1'b1; op = o; size = s; dst = d; src = b; carry_in = c;
    @(negedge clk);
    in_valid = 1'b0; op = 2'b11; dst = 32'hDEAD_BEEF; src = 32'h1234_5678;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        check("R1 unexpected out_valid", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " result"}, result, e.res);
        check({e.tag, " flags"}, flags, e.flg);
        check({e.tag, " flag_we"}, flag_we, e.we);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 out_valid", out_valid, 0);
    check("R10 result", result, 0);
    check("R10 flags", flags, 0);
    check("R10 flag_we", flag_we, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", out_valid, 0);

    drive(2'b00, 2'b00, 32'h0000_007F, 32'h0000_0001, 1'b0, "R5 R6 byte 7F+1");
    drive(2'b00, 2'b00, 32'h0000_00FF, 32'h0000_0001, 1'b0, "R4 R7 byte FF+1");
    drive(2'b00, 2'b00, 32'hABCD_12F0, 32'h5555_AA20, 1'b1, "R2 R3 byte upper ignored");
    drive(2'b01, 2'b01, 32'h0000_FFFF, 32'h0000_0000, 1'b1, "R3 R4 word adc cin=1");
    drive(2'b01, 2'b01, 32'h0000_FFFF, 32'h0000_0000, 1'b0, "R3 word adc cin=0");
    drive(2'b00, 2'b01, 32'hFFFF_7FFF, 32'h0001_0001, 1'b0, "R2 R5 word overflow");
    drive(2'b00, 2'b10, 32'h8000_0000, 32'h8000_0000, 1'b0, "R4 R5 dword sign overflow");
    drive(2'b01, 2'b11, 32'h7FFF_FFFF, 32'h0000_0000, 1'b1, "R2 R5 size11 adc");
    drive(2'b00, 2'b10, 32'h0000_0008, 32'h0000_0008, 1'b0, "R6 R7 aux parity");
    drive(2'b10, 2'b00, 32'hFFFF_FF0F, 32'h0000_00F3, 1'b1, "R8 and byte");
    drive(2'b10, 2'b10, 32'h8000_0003, 32'hC000_0001, 1'b1, "R8 R7 and dword sign");
    drive(2'b10, 2'b01, 32'h0000_F0F0, 32'h0000_0F0F, 1'b1, "R8 R7 and zero");
    drive(2'b11, 2'b10, 32'hFFFF_FFFF, 32'h0000_0001, 1'b1, "R9 reserved op");

    // R1: hold while idle
    repeat (3) @(negedge clk);
    check("R1 hold out_valid", out_valid, 0);
    check("R1 hold flag_we", flag_we, 0);
    check("R9 queue drained", sb.size(), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule